// File: doc/BRIEF.md
# Programmable Interval Timer

A byte-programmed timer with three independent counter channels. Each channel holds a 16-bit programmed count and an elapsed-tick position. It advances only on clock cycles where the shared tick enable is high, and drives one registered output whose waveform depends on the channel's counting mode. There are six modes: terminal count, gate-triggered one-shot, rate generator, square wave, software strobe and gate-triggered strobe. A host writes control words and count bytes through a small byte port, and reads back a live count, a frozen count snapshot or a status byte.

The port has four addresses. Addresses 0 to 2 reach the data byte of channels 0 to 2. Address 3 takes control words: bits 7:6 select the channel (3 selects the multi-channel snapshot command), bits 5:4 select the byte access (0 snapshot count, 1 low byte only, 2 high byte only, 3 low byte then high byte), bits 3:1 select the mode and bit 0 is a decimal flag that is stored and reported but does not change counting. Read data is registered and appears one cycle after the read strobe.

Top module: `ivt_timer`

## Requirements
- R1: After reset every output is 0, and a read of channel 0 returns 0x00, because the count is 0 and so 65536 ticks remain.
- R2: A control word with access field 1 to 3 programs the channel. Its mode is taken from bits 3:1, with 6 and 7 acting as 2 and 3. Its output is forced to 0 in mode 0 and to 1 in any other mode. The channel then waits for a count. The status byte is {out, waiting_for_count, access[1:0], mode[2:0], decimal_flag}.
- R3: Access 1 loads {0x00, byte} and access 2 loads {byte, 0x00}. Access 3 takes the low byte and then the high byte, and the count takes effect only on the second byte. A count of 0 means 65536 ticks. Loading restarts the elapsed count k at 0.
- R4: In modes 0 and 1 the output is 1 exactly when k >= N.
- R5: In mode 2 the output is 0 exactly when k is a nonzero multiple of N.
- R6: In mode 3 the output is 1 exactly when (k mod N) < (N+1)/2, using integer division.
- R7: In modes 4 and 5 the output is 0 only when k equals N. Afterwards it stays 1.
- R8: k advances only on cycles with tick_en high. The output changes on that clock edge and at no other time, except on programming or count load.
- R9: While the channel's gate is low, k is frozen in modes 0, 2, 3 and 4.
- R10: In modes 1, 2, 3 and 5 a rising gate edge makes the next tick restart k at 0.
- R11: The live count reads as (N - k) mod 65536. A count snapshot (access field 0, or command channel 3 with bit 5 at 0 and bit (1+ch) set) freezes that value until it is fully read. With access 3, the low byte is read first.
- R12: The snapshot command with bit 4 at 0 freezes the status of each selected channel. A pending status is returned by the next read, before any count byte.
- R13: Programming, loading or reading one channel leaves the other channels' outputs unchanged.
- R14: rdata carries the selected byte in the cycle after rd_en and is 0x00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0..2 channel data, 3 control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| tick_en | input | 1 | Counting tick enable, shared by all channels |
| gate | input | NUM_CH | Per-channel gate level |
| out | output | NUM_CH | Per-channel registered output |

## Verification
A control write or count load changes out at the same clock edge that captures the write. A tick changes out at the edge where tick_en is sampled high. A read byte appears on rdata at the edge after rd_en. The bench drives every input at the falling edge and samples one falling edge later, so each check lands on the first cycle in which the result is due. The main sweep covers all eight mode codes and counts 1 to 6, comparing the output after every tick against arithmetic on the elapsed tick number.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int PH_W   = CNT_W + 1;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_BOTH = 2'd3
  } acc_e;

  // codes 6 and 7 behave as 2 and 3
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

  // output level after ph elapsed ticks, period n
  function automatic logic wave(input logic [2:0] m,
                                input logic [PH_W-1:0] ph,
                                input logic [PH_W-1:0] n);
    logic [PH_W-1:0] half;
    half = (n + PH_W'(1)) >> 1;
    case (m)
      3'd0, 3'd1: return ph >= n;
      3'd3:       return (ph == n) || (ph < half);
      default:    return ph != n;
    endcase
  endfunction
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode #(
  parameter int NUM_CH = 3
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:1]        wbits,
  output logic [NUM_CH-1:0] prog_we,
  output logic [NUM_CH-1:0] snap_cnt,
  output logic [NUM_CH-1:0] snap_st,
  output logic [NUM_CH-1:0] data_we
);
  localparam logic [1:0] CTL_ADDR = 2'd3;
  logic is_ctl, multi;
  assign is_ctl = wr_en && (addr == CTL_ADDR);
  assign multi  = is_ctl && (wbits[7:6] == 2'd3);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic mine;
    assign mine        = is_ctl && (wbits[7:6] == 2'(i));
    assign data_we[i]  = wr_en && (addr == 2'(i));
    assign prog_we[i]  = mine && (wbits[5:4] != 2'd0);
    assign snap_cnt[i] = (mine && (wbits[5:4] == 2'd0)) ||
                         (multi && !wbits[5] && wbits[1+i]);
    assign snap_st[i]  = multi && !wbits[4] && wbits[1+i];
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              gate,
  input  logic              prog_we,
  input  logic [5:0]        ctl,
  input  logic              snap_cnt,
  input  logic              snap_st,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out
);
  logic [2:0]        mode_q;
  acc_e              acc_q;
  logic              dec_q, wff_q, rff_q, armed_q, trig_q, gate_q, out_q;
  logic              cl_q, sl_q;
  logic [BYTE_W-1:0] lo_q, sl_val;
  logic [CNT_W-1:0]  cnt_q, cl_val, new_cnt, live, src;
  logic [PH_W-1:0]   ph_q, ph_nx, n_full, diff;
  logic              gated_mode, trig_mode, step, load_ev, hi_sel;
  logic [2:0]        new_mode;

  assign n_full     = {(cnt_q == '0), cnt_q};
  assign diff       = n_full - ph_q;
  assign live       = diff[CNT_W-1:0];
  assign gated_mode = !(mode_q[0] && !mode_q[1]);
  assign trig_mode  = mode_q[1] | mode_q[0];
  assign step       = armed_q && tick_en && (gate || !gated_mode);
  assign new_mode   = norm_mode(ctl[3:1]);

  always_comb begin
    if (trig_q)          ph_nx = '0;
    else if (!mode_q[1]) ph_nx = (ph_q > n_full) ? ph_q : ph_q + PH_W'(1);
    else                 ph_nx = (ph_q == n_full) ? PH_W'(1) : ph_q + PH_W'(1);
  end

  always_comb begin
    load_ev = 1'b0;
    new_cnt = cnt_q;
    if (data_we) begin
      case (acc_q)
        ACC_LO:   begin load_ev = 1'b1; new_cnt = {{BYTE_W{1'b0}}, wdata}; end
        ACC_HI:   begin load_ev = 1'b1; new_cnt = {wdata, {BYTE_W{1'b0}}}; end
        ACC_BOTH: begin load_ev = wff_q; new_cnt = {wdata, lo_q}; end
        default:  ;
      endcase
    end
  end

  assign src     = cl_q ? cl_val : live;
  assign hi_sel  = (acc_q == ACC_HI) || ((acc_q == ACC_BOTH) && rff_q);
  assign rd_byte = sl_q ? sl_val : (hi_sel ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0]);
  assign out     = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; acc_q <= ACC_BOTH; dec_q <= 1'b0;
      wff_q <= 1'b0; rff_q <= 1'b0; armed_q <= 1'b0; trig_q <= 1'b0;
      gate_q <= 1'b0; out_q <= 1'b0; cl_q <= 1'b0; sl_q <= 1'b0;
      lo_q <= '0; sl_val <= '0; cnt_q <= '0; cl_val <= '0; ph_q <= '0;
    end else begin
      gate_q <= gate;
      if (step) begin
        ph_q   <= ph_nx;
        out_q  <= wave(mode_q, ph_nx, n_full);
        trig_q <= 1'b0;
      end
      if (gate && !gate_q && trig_mode) trig_q <= 1'b1;
      if (data_we && (acc_q == ACC_BOTH) && !wff_q) begin
        lo_q  <= wdata;
        wff_q <= 1'b1;
      end
      if (load_ev) begin
        cnt_q   <= new_cnt;
        ph_q    <= '0;
        armed_q <= 1'b1;
        trig_q  <= 1'b0;
        wff_q   <= 1'b0;
        out_q   <= (mode_q[2:1] != 2'd0);
      end
      if (snap_cnt && !cl_q) begin
        cl_q   <= 1'b1;
        cl_val <= live;
      end
      if (snap_st && !sl_q) begin
        sl_q   <= 1'b1;
        sl_val <= {out_q, !armed_q, acc_q, mode_q, dec_q};
      end
      if (data_re) begin
        if (sl_q) sl_q <= 1'b0;
        else begin
          if (acc_q == ACC_BOTH) rff_q <= !rff_q;
          if ((acc_q != ACC_BOTH) || rff_q) cl_q <= 1'b0;
        end
      end
      if (prog_we) begin
        mode_q  <= new_mode;
        acc_q   <= acc_e'(ctl[5:4]);
        dec_q   <= ctl[0];
        wff_q   <= 1'b0;
        rff_q   <= 1'b0;
        armed_q <= 1'b0;
        trig_q  <= 1'b0;
        cl_q    <= 1'b0;
        sl_q    <= 1'b0;
        out_q   <= (new_mode != 3'd0);
      end
    end
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              tick_en,
  input  logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] out
);
  logic [NUM_CH-1:0] prog_we, snap_cnt, snap_st, data_we;
  logic [7:0]        ch_byte [NUM_CH];
  logic [7:0]        sel_byte;
  logic [7:0]        rdata_q;

  ivt_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en(wr_en), .addr(addr), .wbits(wdata[7:1]),
    .prog_we(prog_we), .snap_cnt(snap_cnt), .snap_st(snap_st), .data_we(data_we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ivt_channel u_ch (
      .clk(clk), .rst(rst), .tick_en(tick_en), .gate(gate[i]),
      .prog_we(prog_we[i]), .ctl(wdata[5:0]),
      .snap_cnt(snap_cnt[i]), .snap_st(snap_st[i]),
      .data_we(data_we[i]), .data_re(rd_en && (addr == 2'(i))),
      .wdata(wdata), .rd_byte(ch_byte[i]), .out(out[i])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == 2'(i)) sel_byte = ch_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en ? sel_byte : '0;
  end
  assign rdata = rdata_q;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [7:1]        wbits,
  input logic [7:0]        rdata,
  input logic              tick_en,
  input logic [NUM_CH-1:0] out
);
  logic prog0;
  assign prog0 = wr_en && (addr == 2'd3) && (wbits[7:6] == 2'd0) && (wbits[5:4] != 2'd0);

  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out == '0));

  p_mode0_prog_low_r2: assert property (@(posedge clk) disable iff (rst)
    (prog0 && (wbits[3:1] == 3'd0)) |=> !out[0]);

  p_other_prog_high_r2: assert property (@(posedge clk) disable iff (rst)
    (prog0 && (wbits[3:1] != 3'd0)) |=> out[0]);

  p_out_still_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=> $stable(out));

  p_rdata_idle_r14: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == 8'h00));
endmodule

bind ivt_timer ivt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wbits(wdata[7:1]), .rdata(rdata), .tick_en(tick_en), .out(out)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] gate = 3'b111;
  logic [2:0] out;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] b;

  always #4 clk = ~clk;

  ivt_timer #(.NUM_CH(3)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .gate(gate), .out(out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_out(input int m, input int k, input int n);
    case (m)
      0, 1: return k >= n;
      2:    return !((k % n) == 0 && k != 0);
      3:    return (k % n) < ((n + 1) / 2);
      default: return k != n;
    endcase
  endfunction

  task automatic chk_rd(input logic [1:0] a, input int exp, input string tag);
    rd(a, b);
    chk(b == exp, tag, b, exp);
  endtask

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    chk(out == 3'b000, "R1 reset out", out, 0);
    chk_rd(0, 8'h00, "R1 reset count");
    @(negedge clk);
    chk(rdata == 8'h00, "R14 rdata idle", rdata, 0);

    // sweep all mode codes and small counts
    for (int m = 0; m < 8; m++) begin
      for (int n = 1; n <= 6; n++) begin
        int em;
        em = (m > 5) ? m - 4 : m;
        wr(3, {2'b00, 2'b01, 3'(m), 1'b0});
        chk(out[0] == (em != 0), "R2 prog level", out[0], em != 0);
        wr(0, 8'(n));
        chk(out[0] == exp_out(em, 0, n), "R4-7 load level", out[0], exp_out(em, 0, n));
        for (int k = 1; k <= 3 * n + 2; k++) begin
          tick(1);
          case (em)
            0, 1: chk(out[0] == exp_out(em, k, n), "R4 wave", out[0], exp_out(em, k, n));
            2:    chk(out[0] == exp_out(em, k, n), "R5 wave", out[0], exp_out(em, k, n));
            3:    chk(out[0] == exp_out(em, k, n), "R6 wave", out[0], exp_out(em, k, n));
            default: chk(out[0] == exp_out(em, k, n), "R7 wave", out[0], exp_out(em, k, n));
          endcase
        end
        chk(out[2:1] == 2'b00, "R13 others idle", out[2:1], 0);
      end
    end

    // two-byte load, snapshots and status
    wr(3, 8'h30);
    wr(0, 8'h34);
    wr(3, 8'hE2);
    chk_rd(0, 8'h70, "R3 waiting after first byte");
    wr(0, 8'h12);
    tick(5);
    wr(3, 8'h00);
    tick(2);
    chk_rd(0, 8'h2F, "R11 snap lo");
    chk_rd(0, 8'h12, "R11 snap hi");
    chk_rd(0, 8'h2D, "R11 live lo");
    chk_rd(0, 8'h12, "R11 live hi");
    wr(3, 8'hE2);
    chk_rd(0, 8'h30, "R12 status");
    wr(3, 8'hD2);
    tick(1);
    chk_rd(0, 8'h2D, "R11 cmd snap lo");
    chk_rd(0, 8'h12, "R11 cmd snap hi");
    wr(3, 8'hC2);
    chk_rd(0, 8'h30, "R12 status first");
    chk_rd(0, 8'h2C, "R12 then count lo");
    chk_rd(0, 8'h12, "R12 then count hi");
    chk_rd(1, 8'h00, "R13 ch1 untouched");

    // single-byte access
    wr(3, 8'h10); wr(0, 8'h05); tick(2);
    chk_rd(0, 8'h03, "R3 low only");
    wr(3, 8'h20); wr(0, 8'h02); tick(1);
    chk_rd(0, 8'h01, "R3 high only");

    // zero count
    wr(3, 8'h30); wr(0, 8'h00); wr(0, 8'h00);
    chk_rd(0, 8'h00, "R3 zero lo");
    chk_rd(0, 8'h00, "R3 zero hi");
    tick(1);
    chk_rd(0, 8'hFF, "R3 zero lo after tick");
    chk_rd(0, 8'hFF, "R3 zero hi after tick");
    chk(out[0] == 1'b0, "R3 zero out", out[0], 0);

    // alias and decimal flag in status
    wr(3, 8'h1C); wr(3, 8'hE2);
    chk_rd(0, 8'hD4, "R2 alias 6 as 2");
    wr(3, 8'h11); wr(3, 8'hE2);
    chk_rd(0, 8'h51, "R2 decimal flag");

    // tick enable
    wr(3, 8'h10); wr(0, 8'h02); idle(6);
    chk(out[0] == 1'b0, "R8 no tick no change", out[0], 0);
    chk_rd(0, 8'h02, "R8 count held");
    tick(2);
    chk(out[0] == 1'b1, "R8 two ticks", out[0], 1);

    // gate suspend in mode 0
    wr(3, 8'h10); wr(0, 8'h03); tick(1);
    gate[0] = 0; tick(4);
    chk(out[0] == 1'b0, "R9 suspended out", out[0], 0);
    chk_rd(0, 8'h02, "R9 suspended count");
    gate[0] = 1; tick(1);
    chk(out[0] == 1'b0, "R9 resumed k2", out[0], 0);
    tick(1);
    chk(out[0] == 1'b1, "R9 resumed k3", out[0], 1);
    gate[0] = 0; idle(1); gate[0] = 1; idle(1); tick(1);
    chk(out[0] == 1'b1, "R10 mode0 no retrigger", out[0], 1);

    // retrigger mode 1
    wr(3, 8'h12); wr(0, 8'h03); tick(3);
    chk(out[0] == 1'b1, "R4 one-shot done", out[0], 1);
    gate[0] = 0; idle(1); gate[0] = 1; idle(1); tick(1);
    chk(out[0] == 1'b0, "R10 mode1 restart", out[0], 0);
    chk_rd(0, 8'h03, "R10 mode1 count reloaded");
    tick(2);
    chk(out[0] == 1'b0, "R10 mode1 k2", out[0], 0);
    tick(1);
    chk(out[0] == 1'b1, "R10 mode1 k3", out[0], 1);

    // retrigger mode 2
    wr(3, 8'h14); wr(0, 8'h04); tick(2);
    gate[0] = 0; idle(1); gate[0] = 1; idle(1); tick(1);
    chk(out[0] == 1'b1, "R10 mode2 restart", out[0], 1);
    tick(3);
    chk(out[0] == 1'b1, "R10 mode2 k3", out[0], 1);
    tick(1);
    chk(out[0] == 1'b0, "R10 mode2 k4 low", out[0], 0);
    @(negedge clk);
    chk(rdata == 8'h00, "R14 rdata idle end", rdata, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule